// File: doc/BRIEF.md
# Host Port Slave Interface

This block lets an external host reach a 32-bit on-chip memory space over a 16-bit asynchronous bus. The host drives a chip select, two data strobes, a 2-bit register code, a read/write flag and a half-word flag. The block combines the chip select and data strobes into one internal access strobe. It passes every host signal through a two-flop synchronizer, then records the select signals on the falling edge of that strobe.

Three host-visible registers sit behind the bus. A control register holds the half-word ordering bit. An address register points into memory. A data register assembles or splits each 32-bit word as two half-word transfers. Data-register traffic becomes single-word read and write requests on a valid/ready memory port, with an optional address auto-increment and a prefetch of the next word. An active-low ready output tells the host when a data-register access is still completing. Control and address traffic never touches that output.

Top module: `hostPortSlave`

## Requirements
- R1: An access exists only while chip select is low and exactly one data strobe is low. Both strobes low together (with chip select low) change no register.
- R2: The register code, read/write flag and half-word flag are taken when the access strobe falls. Changing them later in the access does not change which register is read. Codes: 00 control, 01 data with auto-increment, 10 address, 11 data with a fixed address. Half-word flag 0 marks the first half-word and 1 the second.
- R3: Bit 0 of the control register sets the ordering. When it is 0, the first half-word is bits 15:0. When it is 1, the first half-word is bits 31:16. The control register reads back with that bit in bit 0 and zeros in every other bit.
- R4: The address register can be written and read one half-word at a time.
- R5: The ready output is low whenever chip select is high.
- R6: A first-half read of the data register issues one memory read at the address register. Ready stays high until the returned word is in the data register, and the host then reads that word's halves.
- R7: The second half-word of a data write issues one memory write of the assembled 32-bit word at the address register. Ready is high until the memory accepts the write. Write data is taken on the strobe rising edge.
- R8: With code 01, the address register grows by 4 after each completed word write or word read. After the second half of such a read, the block fetches the next word at once. A following code-01 first-half read then issues no request and keeps ready low. With code 11, the address does not change.
- R9: Control and address register accesses never raise the ready output.
- R10: If the previous data write is still waiting on memory when chip select falls, ready goes high within the synchronizer delay. It returns low once the write completes.
- R11: The data output enable is high only during a read while the access strobe is low.
- R12: A memory request holds its valid, address, direction and write data steady until the memory accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostDs1N | input | 1 | Host data strobe 1, active low |
| hostDs2N | input | 1 | Host data strobe 2, active low |
| hostCntl | input | 2 | Register code |
| hostRnW | input | 1 | 1 for read, 0 for write |
| hostHalf | input | 1 | 0 first half-word, 1 second |
| hostDataIn | input | 16 | Host write data |
| hostDataOut | output | 16 | Host read data |
| hostDataOe | output | 1 | Output enable for the host data bus |
| hostRdy | output | 1 | Busy indication, high while a data access completes |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | 1 for a write request |
| memReqAddr | output | 32 | Request byte address |
| memReqWdata | output | 32 | Request write data |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Returned read word |

## Verification
The assertions assume a host that behaves. It keeps the strobe low until ready has returned low. It starts no new strobe while a data access is still busy. It holds the selects and write data steady for longer than the synchronizer delay around each strobe edge. The memory is assumed to return exactly one response for each accepted read. The stimulus keeps to this contract: every access waits a fixed number of cycles after each edge, then polls ready before it moves the strobe, and write data stays on the bus for several cycles after the rising edge. Memory stalls are inserted only while the host has chip select high or is idle.

// File: rtl/hps_pkg.sv
package hps_pkg;
  localparam logic [1:0] SEL_CTRL     = 2'b00;
  localparam logic [1:0] SEL_DATA_INC = 2'b01;
  localparam logic [1:0] SEL_ADDR     = 2'b10;
  localparam logic [1:0] SEL_DATA_FIX = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ
  } hpsState_t;

  typedef struct packed {
    logic latchSel;
    logic hostWrite;
    logic incAddr;
    logic loadRdData;
  } hpsStrobes_t;
endpackage

// File: rtl/hpsSync.sv
module hpsSync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VALUE = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RESET_VALUE;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/hpsControl.sv
module hpsControl
  import hps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csSyncN,
  input  logic        ds1SyncN,
  input  logic        ds2SyncN,
  input  logic [1:0]  curCntl,
  input  logic        curRnw,
  input  logic        curHalf,
  input  logic [1:0]  selCntl,
  input  logic        selRnw,
  input  logic        selHalf,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output hpsStrobes_t strobes,
  output logic        hostRdy,
  output logic        hostDataOe,
  output logic        memReqValid,
  output logic        memReqWrite
);
  hpsState_t state, stateNext;
  logic strobeN, strobeDly, strobeFall, strobeRise;
  logic accessActive, activeNext;
  logic prefetchValid, prefetchNext;
  logic fetchNeeded;

  assign strobeN    = ~(ds1SyncN ^ ds2SyncN) | csSyncN;
  assign strobeFall = strobeDly & ~strobeN;
  assign strobeRise = ~strobeDly & strobeN;
  assign fetchNeeded = curCntl[0] && curRnw && !curHalf &&
                       !(curCntl == SEL_DATA_INC && prefetchValid);

  always_comb begin
    stateNext    = state;
    activeNext   = accessActive;
    prefetchNext = prefetchValid;
    strobes      = '0;
    case (state)
      ST_RD_REQ:  if (memReqReady) stateNext = ST_RD_WAIT;
      ST_RD_WAIT: if (memRspValid) begin
        strobes.loadRdData = 1'b1;
        prefetchNext       = 1'b1;
        stateNext          = ST_IDLE;
      end
      ST_WR_REQ:  if (memReqReady) begin
        stateNext = ST_IDLE;
        if (selCntl == SEL_DATA_INC) strobes.incAddr = 1'b1;
      end
      default: ;
    endcase
    if (strobeFall) begin
      strobes.latchSel = 1'b1;
      activeNext       = 1'b1;
      if (fetchNeeded) stateNext = ST_RD_REQ;
    end
    if (strobeRise && accessActive) begin
      activeNext = 1'b0;
      if (!selRnw) begin
        strobes.hostWrite = 1'b1;
        if (selCntl == SEL_ADDR || selCntl[0]) prefetchNext = 1'b0;
        if (selCntl[0] && selHalf) stateNext = ST_WR_REQ;
      end else if (selCntl == SEL_DATA_INC && selHalf) begin
        strobes.incAddr = 1'b1;
        prefetchNext    = 1'b0;
        stateNext       = ST_RD_REQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      strobeDly     <= 1'b1;
      accessActive  <= 1'b0;
      prefetchValid <= 1'b0;
    end else begin
      state         <= stateNext;
      strobeDly     <= strobeN;
      accessActive  <= activeNext;
      prefetchValid <= prefetchNext;
    end
  end

  assign memReqValid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign memReqWrite = (state == ST_WR_REQ);
  assign hostRdy     = ~csSyncN & (state != ST_IDLE);
  assign hostDataOe  = accessActive & selRnw & ~strobeN;
endmodule

// File: rtl/hpsDatapath.sv
module hpsDatapath
  import hps_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpsStrobes_t       strobes,
  input  logic [1:0]        curCntl,
  input  logic              curRnw,
  input  logic              curHalf,
  input  logic [HALF_W-1:0] curData,
  input  logic [DATA_W-1:0] memRspData,
  output logic [1:0]        selCntl,
  output logic              selRnw,
  output logic              selHalf,
  output logic [HALF_W-1:0] hostDataOut,
  output logic [DATA_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata
);
  localparam logic [DATA_W-1:0] ADDR_STEP = (DATA_W)'(DATA_W / 8);

  logic              hwOrder;
  logic [DATA_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic              upperSel;

  assign upperSel = selHalf ^ hwOrder;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selCntl <= SEL_CTRL;
      selRnw  <= 1'b0;
      selHalf <= 1'b0;
      hwOrder <= 1'b0;
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobes.latchSel) begin
        selCntl <= curCntl;
        selRnw  <= curRnw;
        selHalf <= curHalf;
      end
      if (strobes.hostWrite) begin
        case (selCntl)
          SEL_CTRL: hwOrder <= curData[0];
          SEL_ADDR: begin
            if (upperSel) addrReg[DATA_W-1:HALF_W] <= curData;
            else          addrReg[HALF_W-1:0]      <= curData;
          end
          default: begin
            if (upperSel) dataReg[DATA_W-1:HALF_W] <= curData;
            else          dataReg[HALF_W-1:0]      <= curData;
          end
        endcase
      end
      if (strobes.incAddr)    addrReg <= addrReg + ADDR_STEP;
      if (strobes.loadRdData) dataReg <= memRspData;
    end
  end

  always_comb begin
    case (selCntl)
      SEL_CTRL: hostDataOut = {{(HALF_W-1){1'b0}}, hwOrder};
      SEL_ADDR: hostDataOut = upperSel ? addrReg[DATA_W-1:HALF_W] : addrReg[HALF_W-1:0];
      default:  hostDataOut = upperSel ? dataReg[DATA_W-1:HALF_W] : dataReg[HALF_W-1:0];
    endcase
  end

  assign memReqAddr  = addrReg;
  assign memReqWdata = dataReg;
endmodule

// File: rtl/hostPortSlave.sv
module hostPortSlave
  import hps_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostDs1N,
  input  logic              hostDs2N,
  input  logic [1:0]        hostCntl,
  input  logic              hostRnW,
  input  logic              hostHalf,
  input  logic [HALF_W-1:0] hostDataIn,
  output logic [HALF_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic              hostRdy,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [DATA_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData
);
  localparam int BUS_W = HALF_W + 7;

  logic [BUS_W-1:0]  syncIn, syncOut;
  logic              csSyncN, ds1SyncN, ds2SyncN, curRnw, curHalf;
  logic [1:0]        curCntl;
  logic [HALF_W-1:0] curData;
  logic [1:0]        selCntl;
  logic              selRnw, selHalf;
  hpsStrobes_t       strobes;

  assign syncIn = {hostCsN, hostDs1N, hostDs2N, hostRnW, hostHalf, hostCntl, hostDataIn};

  hpsSync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VALUE('1)) u_sync (
    .clk(clk), .rstN(rstN), .din(syncIn), .dout(syncOut)
  );

  assign {csSyncN, ds1SyncN, ds2SyncN, curRnw, curHalf, curCntl, curData} = syncOut;

  hpsControl u_ctrl (
    .clk(clk), .rstN(rstN),
    .csSyncN(csSyncN), .ds1SyncN(ds1SyncN), .ds2SyncN(ds2SyncN),
    .curCntl(curCntl), .curRnw(curRnw), .curHalf(curHalf),
    .selCntl(selCntl), .selRnw(selRnw), .selHalf(selHalf),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .strobes(strobes), .hostRdy(hostRdy), .hostDataOe(hostDataOe),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite)
  );

  hpsDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .curCntl(curCntl), .curRnw(curRnw), .curHalf(curHalf), .curData(curData),
    .memRspData(memRspData),
    .selCntl(selCntl), .selRnw(selRnw), .selHalf(selHalf),
    .hostDataOut(hostDataOut), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata)
  );
endmodule

// File: rtl/hostPortSlave_checker.sv
module hostPortSlave_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostCsN,
  input logic              hostDs1N,
  input logic              hostDs2N,
  input logic              hostRdy,
  input logic              hostDataOe,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [DATA_W-1:0] memReqAddr,
  input logic [DATA_W-1:0] memReqWdata
);
  logic strobeHigh;
  assign strobeHigh = ~(hostDs1N ^ hostDs2N) | hostCsN;

  // R5: chip select high long enough to cross the synchronizer forces ready low
  assert_rdy_low_cs_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostCsN && $past(hostCsN) && $past(hostCsN, 2)) |-> !hostRdy);

  // R11: no bus drive once the strobe has been high past the synchronizer
  assert_oe_off_strobe_high_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobeHigh && $past(strobeHigh) && $past(strobeHigh, 2) && $past(strobeHigh, 3))
      |-> !hostDataOe);

  // R12: a stalled request keeps its content
  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite) && $stable(memReqWdata)));

  // R6: while memory traffic is open and the host is selected, ready shows busy
  assert_busy_during_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !hostCsN && !$past(hostCsN) && !$past(hostCsN, 2)) |-> hostRdy);
endmodule

bind hostPortSlave hostPortSlave_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostDs1N(hostDs1N), .hostDs2N(hostDs2N),
  .hostRdy(hostRdy), .hostDataOe(hostDataOe), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
  .memReqWdata(memReqWdata)
);

// File: tb/hostPortSlave_bench.sv
module hostPortSlave_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        hostCsN = 1'b1, hostDs1N = 1'b1, hostDs2N = 1'b1;
  logic [1:0]  hostCntl = 2'b00;
  logic        hostRnW = 1'b1, hostHalf = 1'b0;
  logic [15:0] hostDataIn = '0;
  logic [15:0] hostDataOut;
  logic        hostDataOe, hostRdy;
  logic        memReqValid, memReqWrite;
  logic        memReqReady;
  logic [31:0] memReqAddr, memReqWdata;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int checks = 0;
  int errors = 0;
  int reqCount = 0;
  bit memStall = 1'b0;
  bit lastBusy;

  logic [31:0] memArr [logic [31:0]];
  logic [31:0] expWrAddr[$], expWrData[$], expRdAddr[$];
  int          rspCnt = 0;
  logic [31:0] rspWord = '0;

  logic        mOrder = 1'b0;
  logic [31:0] mAddr = '0, mData = '0;
  bit          mPref = 1'b0;

  always #2.5 clk = ~clk;
  assign memReqReady = !memStall;

  hostPortSlave u_hostPortSlave (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostDs1N(hostDs1N), .hostDs2N(hostDs2N),
    .hostCntl(hostCntl), .hostRnW(hostRnW), .hostHalf(hostHalf), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe), .hostRdy(hostRdy),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memRead(input logic [31:0] a);
    if (memArr.exists(a)) return memArr[a];
    return a ^ 32'hC0DE_0000;
  endfunction

  // Behavioural memory: accepts on valid&ready, returns reads two cycles later
  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (rspCnt != 0) begin
      rspCnt--;
      if (rspCnt == 0) begin
        memRspValid = 1'b1;
        memRspData  = rspWord;
      end
    end
    if (rstN && memReqValid && memReqReady) begin
      reqCount++;
      if (memReqWrite) begin
        if (expWrAddr.size() == 0) check("R7 unexpected write", memReqAddr, 32'hFFFF_FFFF);
        else begin
          check("R7 write addr", memReqAddr, expWrAddr.pop_front());
          check("R7 write data", memReqWdata, expWrData.pop_front());
        end
        memArr[memReqAddr] = memReqWdata;
      end else begin
        if (expRdAddr.size() == 0) check("R6 unexpected read", memReqAddr, 32'hFFFF_FFFF);
        else check("R6 read addr", memReqAddr, expRdAddr.pop_front());
        rspWord = memRead(memReqAddr);
        rspCnt  = 2;
      end
    end
  end

  // Per-clock comparison of ready and output enable against the host-side model
  int csHighCnt = 0, strobeHighCnt = 0;
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      csHighCnt = hostCsN ? csHighCnt + 1 : 0;
      strobeHighCnt = (~(hostDs1N ^ hostDs2N) | hostCsN) ? strobeHighCnt + 1 : 0;
      if (csHighCnt >= 4) check("R5 ready while deselected", {31'b0, hostRdy}, 32'd0);
      if (strobeHighCnt >= 4) check("R11 oe while strobe high", {31'b0, hostDataOe}, 32'd0);
    end
  end

  task automatic tick();
    @(negedge clk);
    if (!hostCsN && hostRdy) lastBusy = 1'b1;
  endtask

  task automatic hostAccess(input logic [1:0] code, input logic rnw, input logic half,
                            input logic [15:0] wdata, input string req,
                            input bit bothDs = 1'b0, input bit flipSel = 1'b0);
    logic [15:0] expRd;
    logic        idx;
    expRd = '0;
    idx = half ^ mOrder;
    if (!bothDs) begin
      if (code == 2'b00) begin
        if (!rnw) mOrder = wdata[0];
        else expRd = {15'b0, mOrder};
      end else if (code == 2'b10) begin
        if (!rnw) begin mAddr[idx*16 +: 16] = wdata; mPref = 1'b0; end
        else expRd = mAddr[idx*16 +: 16];
      end else if (!rnw) begin
        mData[idx*16 +: 16] = wdata;
        mPref = 1'b0;
        if (half) begin
          expWrAddr.push_back(mAddr);
          expWrData.push_back(mData);
          if (code == 2'b01) mAddr += 32'd4;
        end
      end else if (!half) begin
        if (!(code == 2'b01 && mPref)) begin
          expRdAddr.push_back(mAddr);
          mData = memRead(mAddr);
          mPref = 1'b1;
        end
        expRd = mData[idx*16 +: 16];
      end else begin
        expRd = mData[idx*16 +: 16];
        if (code == 2'b01) begin
          mAddr += 32'd4;
          expRdAddr.push_back(mAddr);
          mData = memRead(mAddr);
          mPref = 1'b1;
        end
      end
    end
    lastBusy = 1'b0;
    tick();
    hostCntl = code; hostRnW = rnw; hostHalf = half; hostDataIn = wdata;
    hostCsN = 1'b0;
    repeat (4) tick();
    while (hostRdy) tick();
    hostDs1N = 1'b0;
    if (bothDs) hostDs2N = 1'b0;
    repeat (2) tick();
    if (flipSel) hostCntl = ~code;
    repeat (4) tick();
    while (hostRdy) tick();
    repeat (2) tick();
    if (rnw && !bothDs) begin
      check({req, " oe during read (R11)"}, {31'b0, hostDataOe}, 32'd1);
      check({req, " read data"}, {16'b0, hostDataOut}, {16'b0, expRd});
    end
    hostDs1N = 1'b1; hostDs2N = 1'b1;
    repeat (5) tick();
    hostCsN = 1'b1;
    repeat (4) tick();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    summary();
    $finish;
  end

  int n;
  initial begin
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 reset ready", {31'b0, hostRdy}, 32'd0);
    check("R11 reset oe", {31'b0, hostDataOe}, 32'd0);
    check("R12 reset request", {31'b0, memReqValid}, 32'd0);

    hostAccess(2'b00, 1'b1, 1'b0, 16'h0, "R3 ctrl reset value");
    check("R9 ctrl read busy", {31'b0, lastBusy}, 32'd0);
    hostAccess(2'b10, 1'b0, 1'b0, 16'h0100, "R4 addr low write");
    check("R9 addr write busy", {31'b0, lastBusy}, 32'd0);
    hostAccess(2'b10, 1'b0, 1'b1, 16'h0000, "R4 addr high write");
    hostAccess(2'b10, 1'b1, 1'b0, 16'h0, "R4 addr low read");
    hostAccess(2'b10, 1'b1, 1'b1, 16'h0, "R4 addr high read");
    check("R9 addr read busy", {31'b0, lastBusy}, 32'd0);

    hostAccess(2'b00, 1'b0, 1'b0, 16'h0001, "R3 ctrl order high first");
    hostAccess(2'b00, 1'b1, 1'b0, 16'h0, "R2 selects held after fall", 1'b0, 1'b1);
    hostAccess(2'b10, 1'b1, 1'b0, 16'h0, "R3 first half is upper");
    hostAccess(2'b10, 1'b1, 1'b1, 16'h0, "R3 second half is lower");
    hostAccess(2'b00, 1'b0, 1'b0, 16'h0000, "R3 ctrl order low first");

    hostAccess(2'b10, 1'b0, 1'b0, 16'hFFFF, "R1 both strobes", 1'b1);
    hostAccess(2'b10, 1'b1, 1'b0, 16'h0, "R1 addr unchanged");

    hostAccess(2'b11, 1'b0, 1'b0, 16'hBEEF, "R7 fixed write first");
    hostAccess(2'b11, 1'b0, 1'b1, 16'hDEAD, "R7 fixed write second");
    check("R7 busy after second half", {31'b0, lastBusy}, 32'd1);
    check("R7 memory word", memRead(32'h100), 32'hDEAD_BEEF);
    hostAccess(2'b10, 1'b1, 1'b0, 16'h0, "R8 fixed address kept");

    n = reqCount;
    hostAccess(2'b11, 1'b1, 1'b0, 16'h0, "R6 fixed read first");
    check("R6 busy on fetch", {31'b0, lastBusy}, 32'd1);
    check("R6 one request", reqCount, n + 1);
    hostAccess(2'b11, 1'b1, 1'b1, 16'h0, "R6 fixed read second");

    hostAccess(2'b01, 1'b0, 1'b0, 16'h2222, "R8 inc write");
    hostAccess(2'b01, 1'b0, 1'b1, 16'h1111, "R8 inc write");
    hostAccess(2'b01, 1'b0, 1'b0, 16'h4444, "R8 inc write");
    hostAccess(2'b01, 1'b0, 1'b1, 16'h3333, "R8 inc write");
    hostAccess(2'b10, 1'b1, 1'b0, 16'h0, "R8 address advanced by 8");

    hostAccess(2'b10, 1'b0, 1'b0, 16'h0100, "R4 addr rewind");
    hostAccess(2'b01, 1'b1, 1'b0, 16'h0, "R8 inc read first");
    hostAccess(2'b01, 1'b1, 1'b1, 16'h0, "R8 inc read second");
    check("R8 busy for prefetch", {31'b0, lastBusy}, 32'd1);
    n = reqCount;
    hostAccess(2'b01, 1'b1, 1'b0, 16'h0, "R8 prefetched first");
    check("R8 no busy on prefetched read", {31'b0, lastBusy}, 32'd0);
    check("R8 no request on prefetched read", reqCount, n);
    hostAccess(2'b01, 1'b1, 1'b1, 16'h0, "R8 prefetched second");

    hostAccess(2'b00, 1'b0, 1'b0, 16'h0001, "R3 order high first");
    hostAccess(2'b10, 1'b0, 1'b0, 16'h0000, "R3 addr upper");
    hostAccess(2'b10, 1'b0, 1'b1, 16'h0200, "R3 addr lower");
    hostAccess(2'b11, 1'b0, 1'b0, 16'hAAAA, "R3 data upper");
    hostAccess(2'b11, 1'b0, 1'b1, 16'h5555, "R3 data lower");
    check("R3 word order", memRead(32'h200), 32'hAAAA_5555);
    hostAccess(2'b00, 1'b0, 1'b0, 16'h0000, "R3 order low first");

    memStall = 1'b1;
    hostAccess(2'b11, 1'b0, 1'b0, 16'h1234, "R10 stalled write first");
    hostAccess(2'b11, 1'b0, 1'b1, 16'h5678, "R10 stalled write second");
    check("R5 ready low while busy and deselected", {31'b0, hostRdy}, 32'd0);
    @(negedge clk);
    hostCsN = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 busy seen on select", {31'b0, hostRdy}, 32'd1);
    check("R12 request still pending", {31'b0, memReqValid}, 32'd1);
    memStall = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 ready low after completion", {31'b0, hostRdy}, 32'd0);
    hostCsN = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 stalled word stored", memRead(32'h200), 32'h5678_1234);
    check("R7 no leftover writes", expWrAddr.size(), 0);
    check("R6 no leftover reads", expRdAddr.size(), 0);

    summary();
    $finish;
  end
endmodule